// File: doc/BRIEF.md
# Variable-Frequency Phase-Accumulator Oscillator

This block is a numerically controlled oscillator. A 16-bit phase register advances once per reference clock by an increment taken from a 16-bit frequency word. The register wraps modulo 2^16, and its top bit is brought out as a square wave. The wave's frequency is the increment times 2^-16 times the reference clock frequency.

The increment is the word itself when the word lies below 0x8000. When the word is 0x8000 or above, the increment is the 16-bit two's complement of the word. The usable increment therefore runs from 1 up to 32768. A one-cycle tick marks every rising edge of the wave. A downstream fixed-frequency pulse-width stage uses that tick as its clock enable.

Dropping the enable clears the phase register on the next clock. A word of zero does the same, so the wave stays low while either condition holds.

Top module: `nco_var_freq`

## Requirements
- R1: While reset is asserted and on the first sample after it, `wave_o` and `rise_tick_o` are 0.
- R2: For a word below 0x8000, the increment equals the word. Word 0x0100 gives exactly 4 rising ticks in the 1024 cycles after enabling from a cleared phase.
- R3: For a word of 0x8000 or above, the increment is (0x10000 - word) mod 2^16. Word 0xFF00 gives 4 ticks in 1024 cycles. Word 0x8000 gives increment 32768 and 512 ticks in 1024 cycles. The increment never exceeds 0x8000.
- R4: While enabled with a nonzero word, the phase adds the increment every cycle modulo 2^16. `wave_o` equals phase bit 15 and matches a cycle-accurate model on every cycle.
- R5: `rise_tick_o` is high for exactly one cycle, and only in the cycle in which `wave_o` has just gone from 0 to 1.
- R6: A power-of-two increment gives a 50% duty wave. Words 0x1000 and 0xC000 each give exactly 32 high cycles out of 64 from a cleared phase.
- R7: A word of 0 clears the phase on the next clock. `wave_o` then stays 0 for as long as the word stays 0.
- R8: With `en` low, the phase is cleared on the next clock. After re-enabling, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en | input | 1 | Run enable; low clears the phase |
| freq_word | input | 16 | Frequency control word |
| wave_o | output | 1 | Square wave, phase bit 15 |
| rise_tick_o | output | 1 | One-cycle pulse on each rising edge of the wave |

## Verification
The hardest case to reach from the ports is a word of zero, or a dropped enable, arriving while the wave is high in the middle of a period. The second-hardest is a word in the upper half, which must fold to the same increment as its mirror. The stimulus first runs a word long enough to drive the wave high, then switches the word to zero or lowers the enable. It then compares mirrored word pairs over fixed windows from a cleared phase. A behavioural model checks the wave and tick on every cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_W = 16;
  localparam int HALF  = 1 << (NCO_W - 1);
  typedef logic [NCO_W-1:0] phase_t;
endpackage

// File: rtl/nco_inc_map.sv
module nco_inc_map
  import nco_pkg::*;
(
  input  phase_t word_i,
  output phase_t inc_o
);
  always_comb begin
    if (word_i[NCO_W-1]) inc_o = (~word_i) + phase_t'(1);
    else                 inc_o = word_i;
  end

  always_comb begin
    assert_inc_range_R3: assert (inc_o <= phase_t'(HALF));
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   halt,
  input  phase_t inc_i,
  output phase_t phase_o
);
  phase_t phase_q, phase_d;
  logic   clear;

  assign clear = !en || halt;

  always_comb begin
    if (clear) phase_d = '0;
    else       phase_d = phase_q + inc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == '0));
  assert_halt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (phase_q == '0));
endmodule

// File: rtl/nco_edge_tick.sv
module nco_edge_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic tick_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  assign tick_o = level_i & ~prev_q;

  assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/nco_var_freq.sv
module nco_var_freq
  import nco_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [15:0] freq_word,
  output logic        wave_o,
  output logic        rise_tick_o
);
  phase_t inc, phase;
  logic   word_zero;

  assign word_zero = (freq_word == '0);

  nco_inc_map u_map (.word_i(freq_word), .inc_o(inc));

  nco_phase_acc u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .halt(word_zero),
    .inc_i(inc), .phase_o(phase)
  );

  assign wave_o = phase[NCO_W-1];

  nco_edge_tick u_tick (
    .clk(clk), .rst_n(rst_n), .level_i(wave_o), .tick_o(rise_tick_o)
  );

  assert_tick_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick_o |-> $rose(wave_o));
  assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_zero || !en) |=> !wave_o);
endmodule

// File: tb/tb_nco_var_freq.sv
module tb_nco_var_freq;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [15:0] freq_word = 16'h0000;
  logic wave_o, rise_tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  nco_var_freq dut (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
    .wave_o(wave_o), .rise_tick_o(rise_tick_o)
  );

  int m_acc = 0;
  int m_prev = 0;

  function automatic int incr(input int w);
    if (w < 32768) return w;
    return (65536 - w) % 65536;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= 0;
      m_prev <= 0;
    end else begin
      m_prev <= (m_acc >= 32768) ? 1 : 0;
      if (!en || freq_word == 16'h0) m_acc <= 0;
      else m_acc <= (m_acc + incr(int'(freq_word))) % 65536;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mw;
      mw = (m_acc >= 32768) ? 1 : 0;
      check(int'(wave_o), mw, "R4 wave vs model");
      check(int'(rise_tick_o), (mw == 1 && m_prev == 0) ? 1 : 0, "R5 tick vs model");
    end
  end

  task automatic restart(input logic [15:0] w);
    @(negedge clk);
    en = 1'b0;
    freq_word = w;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic window(input int n, output int hi, output int ticks);
    hi = 0;
    ticks = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      hi += int'(wave_o);
      ticks += int'(rise_tick_o);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, tk;
    repeat (3) @(negedge clk);
    check(int'(wave_o), 0, "R1 wave in reset");
    check(int'(rise_tick_o), 0, "R1 tick in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(wave_o), 0, "R1 wave after reset");

    restart(16'h0100); window(1024, hi, tk);
    check(tk, 4, "R2 ticks word 0x0100");
    restart(16'h0003); window(300, hi, tk);
    check(tk, 0, "R2 ticks word 0x0003");
    restart(16'hFF00); window(1024, hi, tk);
    check(tk, 4, "R3 ticks word 0xFF00");
    restart(16'h8000); window(1024, hi, tk);
    check(tk, 512, "R3 ticks word 0x8000");
    check(hi, 512, "R6 high count word 0x8000");
    restart(16'h1000); window(64, hi, tk);
    check(hi, 32, "R6 high count word 0x1000");
    check(tk, 4, "R5 ticks word 0x1000");
    restart(16'hC000); window(64, hi, tk);
    check(hi, 32, "R6 high count word 0xC000");
    restart(16'h1234); window(3000, hi, tk);

    restart(16'h4000); window(3, hi, tk);
    check(int'(wave_o), 1, "R7 wave high before zero word");
    freq_word = 16'h0000;
    window(20, hi, tk);
    check(hi, 0, "R7 wave low with zero word");
    check(tk, 0, "R7 no ticks with zero word");

    restart(16'h4000); window(3, hi, tk);
    check(int'(wave_o), 1, "R8 wave high before disable");
    en = 1'b0;
    window(10, hi, tk);
    check(hi, 0, "R8 wave low while disabled");
    en = 1'b1;
    window(2, hi, tk);
    check(hi, 1, "R8 restart from zero phase");
    check(tk, 1, "R8 tick after restart");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule